// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block controls a set of external voltage regulators. It switches each regulator on through one enable output per rail. On a start request it powers the rails up one at a time in a configured slot order. On a stop request it powers them down in the exact reverse of that order. Before each enable or disable step it waits a programmable gap. After the step it waits for that rail's power-good input to follow, and each rail has its own timeout.

A two-bit state output reports the life cycle: Stopped, Starting, Started or Stopping. A trim-enable output is high only while Started, so an external trimming loop runs only while the rails are in regulation. A rail that misses its timeout sets a sticky timeout flag. While Started, any rail that loses power-good or raises a second-level over-voltage or under-voltage flag drops every enable at once and sets a sticky shutdown flag. When logging is enabled, every state change and every fault produces a one-cycle event strobe that carries an event code and a rail index. All configuration comes in on static ports that the host holds stable.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the state is Stopped, every enable is low, both fault flags are low, trim_en is low and no event is strobed.
- R2: The state codes are Stopped=0, Starting=1, Started=2, Stopping=3. A start_req seen at a clock edge while Stopped shows Starting after that edge and clears both sticky fault flags.
- R3: In Starting, the rail in slot k (cfg_order bits [k*IDX_W +: IDX_W]) is enabled for k = 0, 1, ... in order, with at most one new enable per cycle. Each enable follows cfg_gap idle cycles counted from the start of that step: the first enable appears cfg_gap+1 cycles after Starting is shown. The next slot begins only after the enabled rail reports good.
- R4: The state becomes Started only after the last slot's rail reports good. trim_en is high exactly while the state is Started.
- R5: A stop_req in Started shows Stopping after that edge. The rails are then disabled in reverse slot order, each after cfg_gap idle cycles, and each step waits for that rail's good to drop. Stopped follows the slot-0 step, and no enable rises outside Starting.
- R6: If a rail enabled in Starting is not good within cfg_timeout[rail*TMO_W +: TMO_W]+1 cycles, tmo_fault is set and Stopping is shown exactly that many cycles after the enable is seen. The walk-down then starts from that slot, and Started is never reached. In Stopping, a rail that does not drop in its slot sets tmo_fault and the walk continues.
- R7: In Started, if any rail has good low, ov2 high or uv2 high, then after the next edge every enable is low, the state is Stopped and shut_fault is high. This takes priority over a stop_req in the same cycle.
- R8: start_req is ignored in Starting, Started and Stopping. stop_req is ignored in Stopped and Stopping. A stop_req in Starting shows Stopping after that edge.
- R9: With cfg_log_en high, evt_valid pulses for one cycle in the same cycle as the new state or fault. The codes are 1 to Starting, 2 to Started, 3 to Stopping, 4 to Stopped, 5 timeout and 6 fault. For code 5, evt_rail is the timed-out rail; for code 6 it is the lowest-index faulting rail, and a timeout or fault event replaces the state-change event of the same cycle. With cfg_log_en low, evt_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request power-up |
| stop_req | input | 1 | Request power-down |
| cfg_log_en | input | 1 | Enable event strobes |
| cfg_order | input | NUM_RAILS*IDX_W | Rail index per slot, slot 0 in the low bits |
| cfg_gap | input | GAP_W | Idle cycles before each enable or disable |
| cfg_timeout | input | NUM_RAILS*TMO_W | Per-rail response timeout, rail 0 in the low bits |
| rail_good | input | NUM_RAILS | Per-rail power-good / in-range |
| rail_ov2 | input | NUM_RAILS | Per-rail second-level over-voltage |
| rail_uv2 | input | NUM_RAILS | Per-rail second-level under-voltage |
| rail_en | output | NUM_RAILS | Per-rail regulator enable |
| seq_state | output | 2 | Life-cycle state code |
| trim_en | output | 1 | Trimming permitted |
| tmo_fault | output | 1 | Sticky timeout fault |
| shut_fault | output | 1 | Sticky fault-shutdown flag |
| evt_valid | output | 1 | Event strobe |
| evt_rail | output | IDX_W | Event rail index |
| evt_code | output | 3 | Event code |

## Verification
Fault shutdown and a normal stop request can land in the same cycle while Started. The bench provokes this by raising an over-voltage flag and stop_req at the same falling edge. It judges the result one edge later: the state must be Stopped rather than Stopping, all enables must be low and shut_fault must be set. The same scheme is used for two faulting rails in one cycle, where the logged rail must be the lower index.

// File: rtl/rseq_pkg.sv
// Shared types for the rail sequencer: life-cycle states, step phases
// and event codes. Assumes no other package defines these names.
package rseq_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_STARTING = 2'd1,
        ST_STARTED  = 2'd2,
        ST_STOPPING = 2'd3
    } seq_state_e;

    typedef enum logic {
        PH_GAP  = 1'b0,
        PH_WAIT = 1'b1
    } step_phase_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_START = 3'd1,
        EV_UP    = 3'd2,
        EV_DOWN  = 3'd3,
        EV_OFF   = 3'd4,
        EV_TMO   = 3'd5,
        EV_FLT   = 3'd6
    } ev_code_e;

endpackage

// File: rtl/rseq_rail_monitor.sv
// Combines per-rail good, ov2 and uv2 inputs into a single fault flag and
// the lowest faulting rail index. Purely combinational; assumes the inputs
// are already synchronous to the sequencer clock.
module rseq_rail_monitor #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     rail_good,
    input  logic [N-1:0]     rail_ov2,
    input  logic [N-1:0]     rail_uv2,
    output logic             flt_any,
    output logic [IDX_W-1:0] flt_idx
);

    logic [N-1:0] bad;

    // Per-rail bad condition: lost good or second-level excursion.
    assign bad = ~rail_good | rail_ov2 | rail_uv2;

    // Reduce to an any-flag and the lowest flagged index.
    always_comb begin
        flt_any = |bad;
        flt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bad[i]) flt_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rseq_step_timer.sv
// Step counter for the gap and timeout phases. Clear has priority over
// increment; the caller never increments past its compare limit.
module rseq_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end

endmodule

// File: rtl/rseq_event_reg.sv
// Registers an event request so that the strobe lines up with the state
// change it describes. Suppressed entirely while logging is disabled.
module rseq_event_reg
    import rseq_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             log_en,
    input  logic             fire,
    input  ev_code_e         code,
    input  logic [IDX_W-1:0] rail,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_rail,
    output logic [2:0]       evt_code
);

    // Capture one event per cycle when logging is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_rail  <= '0;
            evt_code  <= 3'd0;
        end else begin
            evt_valid <= fire && log_en;
            evt_rail  <= (fire && log_en) ? rail : '0;
            evt_code  <= (fire && log_en) ? code : EV_NONE;
        end
    end

    // R9: no strobe follows a cycle with logging disabled.
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !log_en |=> !evt_valid);

endmodule

// File: rtl/rseq_core.sv
// Life-cycle state machine: walks rail slots up in order and down in
// reverse, times gaps and responses, latches sticky faults and requests
// events. Assumes the configuration ports are static while not Stopped.
module rseq_core
    import rseq_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int GAP_W = 8,
    parameter int TMO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic [N*IDX_W-1:0] cfg_order,
    input  logic [GAP_W-1:0]   cfg_gap,
    input  logic [N*TMO_W-1:0] cfg_timeout,
    input  logic [N-1:0]       rail_good,
    input  logic               flt_any,
    input  logic [IDX_W-1:0]   flt_idx,
    output logic [N-1:0]       rail_en,
    output seq_state_e         state,
    output logic               tmo_fault,
    output logic               shut_fault,
    output logic               ev_fire,
    output ev_code_e           ev_code,
    output logic [IDX_W-1:0]   ev_rail
);

    localparam int CNT_W = (GAP_W > TMO_W) ? GAP_W : TMO_W;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N - 1);

    seq_state_e        st_q, st_d;
    step_phase_e       ph_q, ph_d;
    logic [IDX_W-1:0]  slot_q, slot_d;
    logic [N-1:0]      en_q, en_d;
    logic              tmo_q, tmo_d, shut_q, shut_d;
    logic              cnt_clr, cnt_inc;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  cur_rail;
    logic [TMO_W-1:0]  cur_tmo;
    logic              cur_good, gap_done, tmo_hit;

    rseq_step_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Decode the rail under the current slot and its limits.
    always_comb begin
        cur_rail = cfg_order[slot_q*IDX_W +: IDX_W];
        cur_tmo  = cfg_timeout[cur_rail*TMO_W +: TMO_W];
        cur_good = rail_good[cur_rail];
        gap_done = (cnt == CNT_W'(cfg_gap));
        tmo_hit  = (cnt == CNT_W'(cur_tmo));
    end

    // Next-state logic for the life cycle and the slot walk.
    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        slot_d  = slot_q;
        en_d    = en_q;
        tmo_d   = tmo_q;
        shut_d  = shut_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        ev_fire = 1'b0;
        ev_code = EV_NONE;
        ev_rail = cur_rail;
        unique case (st_q)
            ST_STOPPED: begin
                if (start_req) begin
                    st_d    = ST_STARTING;
                    slot_d  = '0;
                    ph_d    = PH_GAP;
                    cnt_clr = 1'b1;
                    tmo_d   = 1'b0;
                    shut_d  = 1'b0;
                    ev_fire = 1'b1;
                    ev_code = EV_START;
                end
            end
            ST_STARTING: begin
                if (stop_req) begin
                    st_d    = ST_STOPPING;
                    ph_d    = PH_GAP;
                    cnt_clr = 1'b1;
                    ev_fire = 1'b1;
                    ev_code = EV_DOWN;
                end else if (ph_q == PH_GAP) begin
                    if (gap_done) begin
                        en_d[cur_rail] = 1'b1;
                        ph_d    = PH_WAIT;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end else if (cur_good) begin
                    cnt_clr = 1'b1;
                    if (slot_q == LAST_SLOT) begin
                        st_d    = ST_STARTED;
                        ev_fire = 1'b1;
                        ev_code = EV_UP;
                    end else begin
                        slot_d = slot_q + 1'b1;
                        ph_d   = PH_GAP;
                    end
                end else if (tmo_hit) begin
                    tmo_d   = 1'b1;
                    st_d    = ST_STOPPING;
                    ph_d    = PH_GAP;
                    cnt_clr = 1'b1;
                    ev_fire = 1'b1;
                    ev_code = EV_TMO;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_STARTED: begin
                if (flt_any) begin
                    en_d    = '0;
                    st_d    = ST_STOPPED;
                    shut_d  = 1'b1;
                    ev_fire = 1'b1;
                    ev_code = EV_FLT;
                    ev_rail = flt_idx;
                end else if (stop_req) begin
                    st_d    = ST_STOPPING;
                    ph_d    = PH_GAP;
                    cnt_clr = 1'b1;
                    ev_fire = 1'b1;
                    ev_code = EV_DOWN;
                end
            end
            ST_STOPPING: begin
                if (ph_q == PH_GAP) begin
                    if (gap_done) begin
                        en_d[cur_rail] = 1'b0;
                        ph_d    = PH_WAIT;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end else if (!cur_good || tmo_hit) begin
                    cnt_clr = 1'b1;
                    if (cur_good) begin
                        tmo_d   = 1'b1;
                        ev_fire = 1'b1;
                        ev_code = EV_TMO;
                    end
                    if (slot_q == '0) begin
                        st_d = ST_STOPPED;
                        if (!cur_good) begin
                            ev_fire = 1'b1;
                            ev_code = EV_OFF;
                        end
                    end else begin
                        slot_d = slot_q - 1'b1;
                        ph_d   = PH_GAP;
                    end
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: st_d = ST_STOPPED;
        endcase
    end

    // State, slot, enable and sticky-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_STOPPED;
            ph_q   <= PH_GAP;
            slot_q <= '0;
            en_q   <= '0;
            tmo_q  <= 1'b0;
            shut_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            slot_q <= slot_d;
            en_q   <= en_d;
            tmo_q  <= tmo_d;
            shut_q <= shut_d;
        end
    end

    assign rail_en    = en_q;
    assign state      = st_q;
    assign tmo_fault  = tmo_q;
    assign shut_fault = shut_q;

    // R1: reset leaves everything off and Stopped.
    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && st_q == ST_STOPPED && !tmo_q && !shut_q));

    // R3: enables rise one at a time.
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(en_q & ~$past(en_q)) <= 1);

    // R5: no enable rises unless the edge was taken in Starting.
    a_r5_no_rise_outside_up: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_STARTING) |=> ((en_q & ~$past(en_q)) == '0));

    // R6: a timeout excludes Started until the next start.
    a_r6_tmo_never_started: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (st_q != ST_STARTED));

    // R7: a fault in Started drops everything on the next edge.
    a_r7_fault_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STARTED && flt_any) |=> (en_q == '0 && st_q == ST_STOPPED && shut_q));

    // R8: start is ignored while powering down.
    a_r8_start_ignored_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOPPING && start_req) |=> (st_q != ST_STARTING));

endmodule

// File: rtl/rail_seq_ctrl.sv
// Top of the multi-rail power sequencer. Connects the rail fault monitor,
// the life-cycle core and the event register. Assumes all inputs are
// synchronous to clk and configuration is static outside Stopped.
module rail_seq_ctrl
    import rseq_pkg::*;
#(
    parameter int NUM_RAILS = 4,
    parameter int GAP_W     = 8,
    parameter int TMO_W     = 8,
    localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_req,
    input  logic                       stop_req,
    input  logic                       cfg_log_en,
    input  logic [NUM_RAILS*IDX_W-1:0] cfg_order,
    input  logic [GAP_W-1:0]           cfg_gap,
    input  logic [NUM_RAILS*TMO_W-1:0] cfg_timeout,
    input  logic [NUM_RAILS-1:0]       rail_good,
    input  logic [NUM_RAILS-1:0]       rail_ov2,
    input  logic [NUM_RAILS-1:0]       rail_uv2,
    output logic [NUM_RAILS-1:0]       rail_en,
    output logic [1:0]                 seq_state,
    output logic                       trim_en,
    output logic                       tmo_fault,
    output logic                       shut_fault,
    output logic                       evt_valid,
    output logic [IDX_W-1:0]           evt_rail,
    output logic [2:0]                 evt_code
);

    logic             flt_any;
    logic [IDX_W-1:0] flt_idx;
    seq_state_e       state;
    logic             ev_fire;
    ev_code_e         ev_code;
    logic [IDX_W-1:0] ev_rail;

    rseq_rail_monitor #(.N(NUM_RAILS), .IDX_W(IDX_W)) u_mon (
        .rail_good (rail_good),
        .rail_ov2  (rail_ov2),
        .rail_uv2  (rail_uv2),
        .flt_any   (flt_any),
        .flt_idx   (flt_idx)
    );

    rseq_core #(.N(NUM_RAILS), .IDX_W(IDX_W), .GAP_W(GAP_W), .TMO_W(TMO_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .cfg_order   (cfg_order),
        .cfg_gap     (cfg_gap),
        .cfg_timeout (cfg_timeout),
        .rail_good   (rail_good),
        .flt_any     (flt_any),
        .flt_idx     (flt_idx),
        .rail_en     (rail_en),
        .state       (state),
        .tmo_fault   (tmo_fault),
        .shut_fault  (shut_fault),
        .ev_fire     (ev_fire),
        .ev_code     (ev_code),
        .ev_rail     (ev_rail)
    );

    rseq_event_reg #(.IDX_W(IDX_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_en    (cfg_log_en),
        .fire      (ev_fire),
        .code      (ev_code),
        .rail      (ev_rail),
        .evt_valid (evt_valid),
        .evt_rail  (evt_rail),
        .evt_code  (evt_code)
    );

    // State code out and the trimming permission derived from it.
    assign seq_state = state;
    assign trim_en   = (state == ST_STARTED);

endmodule

// File: tb/rail_seq_ctrl_tb_top.sv
// Self-checking bench: randomized orders, gaps and rail delays plus
// directed timeout, fault and request-collision cases.
module rail_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int IW = 2;
    localparam int GW = 8;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0, log_en = 1'b0;
    logic [N*IW-1:0] cfg_order;
    logic [GW-1:0] cfg_gap = '0;
    logic [N*TW-1:0] cfg_timeout;
    logic [N-1:0] rail_good = '0, rail_ov2 = '0, rail_uv2 = '0;
    logic [N-1:0] rail_en;
    logic [1:0] seq_state;
    logic trim_en, tmo_fault, shut_fault, evt_valid;
    logic [IW-1:0] evt_rail;
    logic [2:0] evt_code;

    int ord [N];
    int tmo [N];
    int rdly [N];
    int rcnt [N];
    bit stuck_lo [N];
    bit stuck_hi [N];
    bit force_lo [N];

    int n_chk = 0, n_fail = 0;
    int cyc_n = 0, trim_bad = 0;
    int up_n, dn_n, ev_n;
    int up_seq [16], up_cyc [16], dn_seq [16];
    int ev_c [64], ev_r [64];
    int st1_cyc, st3_cyc;
    logic [N-1:0] prev_en = '0;
    logic [1:0] prev_st = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_order[i*IW +: IW]   = IW'(ord[i]);
            cfg_timeout[i*TW +: TW] = TW'(tmo[i]);
        end
    end

    rail_seq_ctrl #(.NUM_RAILS(N), .GAP_W(GW), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .cfg_log_en(log_en), .cfg_order(cfg_order), .cfg_gap(cfg_gap),
        .cfg_timeout(cfg_timeout), .rail_good(rail_good), .rail_ov2(rail_ov2),
        .rail_uv2(rail_uv2), .rail_en(rail_en), .seq_state(seq_state),
        .trim_en(trim_en), .tmo_fault(tmo_fault), .shut_fault(shut_fault),
        .evt_valid(evt_valid), .evt_rail(evt_rail), .evt_code(evt_code)
    );

    // Regulator model: good follows enable after rdly cycles.
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            bit tgt;
            tgt = (rail_en[i] && !stuck_lo[i]) || (stuck_hi[i] && rail_good[i]);
            if (force_lo[i]) begin
                rail_good[i] = 1'b0; rcnt[i] = 0;
            end else if (rail_good[i] != tgt) begin
                rcnt[i]++;
                if (rcnt[i] >= rdly[i]) begin rail_good[i] = tgt; rcnt[i] = 0; end
            end else rcnt[i] = 0;
        end
    end

    // Observer: enable edges, state entries, events, trim consistency.
    always @(negedge clk) begin
        cyc_n++;
        for (int i = 0; i < N; i++) begin
            if (rail_en[i] && !prev_en[i] && up_n < 16) begin
                up_seq[up_n] = i; up_cyc[up_n] = cyc_n; up_n++;
            end
            if (!rail_en[i] && prev_en[i] && dn_n < 16) begin
                dn_seq[dn_n] = i; dn_n++;
            end
        end
        if (seq_state == 2'd1 && prev_st != 2'd1) st1_cyc = cyc_n;
        if (seq_state == 2'd3 && prev_st != 2'd3) st3_cyc = cyc_n;
        if (evt_valid && ev_n < 64) begin
            ev_c[ev_n] = int'(evt_code); ev_r[ev_n] = int'(evt_rail); ev_n++;
        end
        if (trim_en != (seq_state == 2'd2)) trim_bad++;
        prev_en = rail_en;
        prev_st = seq_state;
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        if (cyc_n > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic clear_rec();
        up_n = 0; dn_n = 0; ev_n = 0;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; step(); start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; step(); stop_req = 1'b0;
    endtask

    task automatic wait_state(input int s, input int lim, output bit hit);
        hit = 0;
        for (int k = 0; k < lim; k++) begin
            if (int'(seq_state) == s) begin hit = 1; break; end
            step();
        end
    endtask

    function automatic int exp_dn(input int k);
        return ord[N-1-k];
    endfunction

    task automatic shuffle();
        for (int i = 0; i < N; i++) ord[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            int j, t;
            j = int'($urandom % (i + 1));
            t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
    endtask

    task automatic bring_up();
        bit hit;
        pulse_start();
        wait_state(2, 600, hit);
        chk(hit, "R4 reach Started", int'(seq_state), 2);
    endtask

    initial begin
        bit hit;
        int seed_v;
        seed_v = int'($urandom(32'd7321));
        for (int i = 0; i < N; i++) begin
            ord[i] = i; tmo[i] = 20; rdly[i] = 2; rcnt[i] = 0;
            stuck_lo[i] = 0; stuck_hi[i] = 0; force_lo[i] = 0;
        end
        clear_rec();
        idle(4);
        // R1: reset state
        chk(rail_en == '0 && seq_state == 2'd0, "R1 reset off", int'(rail_en), 0);
        chk(!tmo_fault && !shut_fault && !trim_en && !evt_valid, "R1 reset flags",
            int'({tmo_fault, shut_fault, trim_en, evt_valid}), 0);
        rst_n = 1'b1;
        step();
        chk(rail_en == '0 && seq_state == 2'd0, "R1 after release", int'(seq_state), 0);

        // R8: stop in Stopped is ignored
        pulse_stop();
        chk(seq_state == 2'd0, "R8 stop ignored in Stopped", int'(seq_state), 0);

        // Randomized up/down cycles
        for (int it = 0; it < 6; it++) begin
            shuffle();
            cfg_gap = GW'($urandom % 4);
            for (int i = 0; i < N; i++) rdly[i] = 1 + int'($urandom % 5);
            log_en = 1'($urandom % 2);
            idle(12);
            clear_rec();
            pulse_start();
            chk(seq_state == 2'd1, "R2 start to Starting", int'(seq_state), 1);
            if (it == 1) begin
                pulse_start();
                chk(seq_state == 2'd1, "R8 start ignored in Starting", int'(seq_state), 1);
            end
            wait_state(2, 600, hit);
            chk(hit, "R4 reach Started", int'(seq_state), 2);
            chk(trim_en, "R4 trim_en in Started", int'(trim_en), 1);
            chk(up_n == N, "R3 enable count", up_n, N);
            for (int k = 0; k < N; k++)
                chk(up_seq[k] == ord[k], "R3 up order", up_seq[k], ord[k]);
            chk(up_cyc[0] - st1_cyc == int'(cfg_gap) + 1, "R3 first gap",
                up_cyc[0] - st1_cyc, int'(cfg_gap) + 1);
            for (int k = 1; k < N; k++)
                chk(up_cyc[k] - up_cyc[k-1] >= int'(cfg_gap) + 2, "R3 gap between rails",
                    up_cyc[k] - up_cyc[k-1], int'(cfg_gap) + 2);
            if (log_en) begin
                chk(ev_n == 2 && ev_c[0] == 1 && ev_c[1] == 2, "R9 up events", ev_n, 2);
            end else begin
                chk(ev_n == 0, "R9 no events when off", ev_n, 0);
            end
            if (it == 2) begin
                pulse_start();
                chk(seq_state == 2'd2, "R8 start ignored in Started", int'(seq_state), 2);
            end
            clear_rec();
            pulse_stop();
            chk(seq_state == 2'd3, "R5 stop to Stopping", int'(seq_state), 3);
            wait_state(0, 600, hit);
            chk(hit, "R5 reach Stopped", int'(seq_state), 0);
            chk(dn_n == N, "R5 disable count", dn_n, N);
            for (int k = 0; k < N; k++)
                chk(dn_seq[k] == exp_dn(k), "R5 reverse order", dn_seq[k], exp_dn(k));
            chk(!tmo_fault && !shut_fault, "R5 clean stop", int'(tmo_fault), 0);
            if (log_en)
                chk(ev_n == 2 && ev_c[0] == 3 && ev_c[1] == 4, "R9 down events", ev_c[1], 4);
        end
        chk(trim_bad == 0, "R4 trim_en tracks Started", trim_bad, 0);

        // R6: rail in slot 2 never comes good
        ord[0] = 2; ord[1] = 0; ord[2] = 3; ord[3] = 1;
        for (int i = 0; i < N; i++) begin rdly[i] = 2; tmo[i] = 6; end
        cfg_gap = 8'd1; log_en = 1'b1;
        stuck_lo[ord[2]] = 1;
        idle(12); clear_rec();
        pulse_start();
        wait_state(3, 600, hit);
        chk(hit && tmo_fault, "R6 timeout to Stopping", int'(tmo_fault), 1);
        chk(up_n == 3, "R6 enables before timeout", up_n, 3);
        chk(st3_cyc - up_cyc[2] == tmo[ord[2]] + 1, "R6 timeout cycle",
            st3_cyc - up_cyc[2], tmo[ord[2]] + 1);
        wait_state(0, 600, hit);
        chk(hit && rail_en == '0, "R6 ends Stopped", int'(rail_en), 0);
        chk(dn_n == 3 && dn_seq[0] == up_seq[2] && dn_seq[2] == up_seq[0],
            "R6 walk down from slot", dn_seq[0], up_seq[2]);
        chk(ev_n >= 3 && ev_c[1] == 5 && ev_r[1] == ord[2], "R9 timeout event rail",
            ev_r[1], ord[2]);
        chk(ev_c[ev_n-1] == 4, "R9 off event last", ev_c[ev_n-1], 4);
        stuck_lo[ord[2]] = 0;

        // R6: rail refuses to drop during Stopping
        for (int i = 0; i < N; i++) tmo[i] = 8;
        idle(12);
        bring_up();
        chk(tmo_fault == 1'b0, "R2 start clears tmo_fault", int'(tmo_fault), 0);
        stuck_hi[ord[1]] = 1;
        pulse_stop();
        wait_state(0, 600, hit);
        chk(hit && tmo_fault && rail_en == '0, "R6 stopping timeout continues",
            int'(tmo_fault), 1);
        stuck_hi[ord[1]] = 0;

        // R7: ov2 on rail 3
        idle(12); clear_rec();
        bring_up();
        rail_ov2[3] = 1'b1; step();
        chk(rail_en == '0 && seq_state == 2'd0 && shut_fault, "R7 ov2 shutdown",
            int'(rail_en), 0);
        chk(ev_c[ev_n-1] == 6 && ev_r[ev_n-1] == 3, "R9 fault event rail 3", ev_r[ev_n-1], 3);
        rail_ov2[3] = 1'b0;

        // R7: two rails in one cycle, lowest index logged
        idle(12); clear_rec();
        bring_up();
        chk(shut_fault == 1'b0, "R2 start clears shut_fault", int'(shut_fault), 0);
        rail_uv2[2] = 1'b1; rail_ov2[1] = 1'b1; step();
        chk(rail_en == '0 && seq_state == 2'd0, "R7 uv2 shutdown", int'(seq_state), 0);
        chk(ev_r[ev_n-1] == 1, "R9 lowest faulting rail", ev_r[ev_n-1], 1);
        rail_uv2[2] = 1'b0; rail_ov2[1] = 1'b0;

        // R7: rail loses good
        idle(12); clear_rec();
        bring_up();
        force_lo[0] = 1; rail_good[0] = 1'b0; step();
        chk(rail_en == '0 && shut_fault, "R7 lost good shutdown", int'(rail_en), 0);
        force_lo[0] = 0;

        // R7 with R8: fault and stop in the same cycle, fault wins
        idle(12); clear_rec();
        bring_up();
        rail_ov2[0] = 1'b1; stop_req = 1'b1; step(); stop_req = 1'b0;
        chk(seq_state == 2'd0 && rail_en == '0, "R7 fault beats stop", int'(seq_state), 0);
        rail_ov2[0] = 1'b0;

        // R8: abort during Starting, start ignored during Stopping
        cfg_gap = 8'd4;
        idle(12); clear_rec();
        pulse_start();
        idle(3);
        pulse_stop();
        chk(seq_state == 2'd3, "R8 stop aborts Starting", int'(seq_state), 3);
        pulse_start();
        chk(seq_state == 2'd3, "R8 start ignored in Stopping", int'(seq_state), 3);
        wait_state(0, 600, hit);
        chk(hit && rail_en == '0, "R8 abort ends Stopped", int'(rail_en), 0);

        // R9: logging off stays silent through a fault
        log_en = 1'b0; cfg_gap = 8'd0;
        idle(12); clear_rec();
        bring_up();
        rail_ov2[2] = 1'b1; step(); rail_ov2[2] = 1'b0;
        idle(2);
        chk(ev_n == 0, "R9 silent with logging off", ev_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule